// File: doc/BRIEF.md
# Three-Wire Synthesizer Programming Interface

This block is a serial slave for a host microcontroller. The host drives three lines: a serial clock, serial data and an enable level. Each frame is shifted in and then written to one of the synthesizer's holding registers. There are two channel-counter words (transmit and receive), a control word, and a reference-divider word with two option bits. A separate local-oscillator capacitor-select word is also reachable. The registers drive the divider and control logic in parallel.

The three serial lines are asynchronous to the crystal clock. They are oversampled in the crystal clock domain, so the whole block runs on one clock. The enable level decides the kind of frame. While enable is low, the frame is a counter/control frame. While enable is high, the frame carries the capacitor select. A frame ends when enable changes level.

The block also divides the crystal clock for the host. The ratio and the on/off gate come from fields of the control word. A new setting is adopted only at the end of a complete output period, so the output never shows a short pulse.

Top module: `tw_prog_if`

## Requirements
- R1: Serial data is sampled when a rising serial-clock edge is seen and enters the frame most significant bit first. The first bit sent ends up as frame bit 15.
- R2: Frame bits 15:14 select the destination: 00 = transmit counter, 01 = receive counter, 10 = control word, 11 = reference word. For the first three, bits 13:0 are written unchanged to the 14-bit register.
- R3: A reference frame writes bits 13:12 to the 2-bit reference option output and bits 11:0 to the 12-bit reference divider output.
- R4: A frame sent while enable is low takes effect on the rising edge of enable only if it held exactly 16 bits. A frame with fewer or more bits changes no register.
- R5: A frame sent while enable is high writes its bits to the capacitor-select register on the falling edge of enable, only if it held exactly CAP_W bits (default 6). Its last bit becomes bit 0. Capacitor frames never alter the counter, control or reference registers.
- R6: After reset, every register reads zero except the control word, which reads 0x0004.
- R7: Control bits 1:0 select the host clock ratio, and each output period starts with its high phase: 00 gives divide-by-2 (high 1, low 1); 01 gives divide-by-3 (high 1, low 2); 10 gives divide-by-4 (high 2, low 2); 11 gives divide-by-5 (high 2, low 3).
- R8: Control bit 2 gates the host clock. When it is 0 the output stays low; when it is 1 the output runs.
- R9: A change of ratio or gate takes effect only after the low phase of the current period ends. The output never shows a high run longer than 2 cycles or a low run longer than 3 while running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Crystal clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ser_clk_i | input | 1 | Serial clock from the host |
| ser_dat_i | input | 1 | Serial data from the host |
| ser_en_i | input | 1 | Enable level; its level picks the frame kind and its edge ends a frame |
| tx_div_o | output | 14 | Transmit channel counter word |
| rx_div_o | output | 14 | Receive channel counter word |
| ctrl_o | output | 14 | Control word |
| ref_div_o | output | 12 | Reference divider word |
| ref_opt_o | output | 2 | Reference option bits |
| lo_cap_o | output | CAP_W | Local-oscillator capacitor select |
| host_clk_o | output | 1 | Divided crystal clock for the host |

## Verification
Two functions can fall in the same cycle: a control-frame commit that changes the ratio or the gate, and the divider's period boundary.

The bench provokes this by rewriting the ratio several times while the host clock is running. The commits therefore land at arbitrary phases of the output period.

Every high and low run of the output is measured at the port and judged against the bounds of R9. The period that follows each change is checked against the new ratio, and an assertion confirms that the adopted setting only ever changes after a low output cycle.

// File: rtl/tw_prog_pkg.sv
package tw_prog_pkg;
    localparam int MODE_W   = 2;
    localparam int CNT_W    = 14;
    localparam int REF_W    = 12;
    localparam int OPT_W    = 2;
    localparam int FRAME_W  = MODE_W + CNT_W;
    localparam int BITCNT_W = $clog2(FRAME_W + 2);
    localparam int SEL_W    = 2;
    localparam int GATE_BIT = 2;
    localparam int DIV_W    = $clog2((1 << SEL_W) + 2);
    localparam logic [CNT_W-1:0] CTRL_RST = CNT_W'(4);

    typedef enum logic [MODE_W-1:0] {
        M_TX   = 2'b00,
        M_RX   = 2'b01,
        M_CTRL = 2'b10,
        M_REF  = 2'b11
    } mode_e;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
    parameter int LINES  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [LINES-1:0] async_i,
    output logic [LINES-1:0] sync_o
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], async_i[g]};
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q <= '0;
            else         chain_q <= chain_d;
        end

        assign sync_o[g] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/tw_frame_rx.sv
module tw_frame_rx
    import tw_prog_pkg::*;
#(
    parameter int CAP_W = 6
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             sclk_s_i,
    input  logic             sdat_s_i,
    input  logic             sen_s_i,
    output logic [CNT_W-1:0] tx_o,
    output logic [CNT_W-1:0] rx_o,
    output logic [CNT_W-1:0] ctrl_o,
    output logic [REF_W-1:0] ref_o,
    output logic [OPT_W-1:0] opt_o,
    output logic [CAP_W-1:0] cap_o,
    output logic             commit_lo_o,
    output logic             commit_hi_o
);
    typedef struct packed {
        logic                sclk_prev;
        logic                sen_lvl;
        logic [FRAME_W-1:0]  sh;
        logic [BITCNT_W-1:0] cnt;
        logic [CNT_W-1:0]    tx;
        logic [CNT_W-1:0]    rx;
        logic [CNT_W-1:0]    ctrl;
        logic [REF_W-1:0]    refd;
        logic [OPT_W-1:0]    opt;
        logic [CAP_W-1:0]    cap;
    } state_t;

    state_t st_d, st_q;
    logic   commit_lo, commit_hi;

    always_comb begin
        st_d          = st_q;
        commit_lo     = 1'b0;
        commit_hi     = 1'b0;
        st_d.sclk_prev = sclk_s_i;
        if (sen_s_i != st_q.sen_lvl) begin
            st_d.sen_lvl = sen_s_i;
            st_d.cnt     = '0;
            if (!st_q.sen_lvl && st_q.cnt == BITCNT_W'(FRAME_W)) begin
                commit_lo = 1'b1;
                case (mode_e'(st_q.sh[FRAME_W-1 -: MODE_W]))
                    M_TX:   st_d.tx   = st_q.sh[CNT_W-1:0];
                    M_RX:   st_d.rx   = st_q.sh[CNT_W-1:0];
                    M_CTRL: st_d.ctrl = st_q.sh[CNT_W-1:0];
                    default: begin
                        st_d.opt  = st_q.sh[REF_W+OPT_W-1 -: OPT_W];
                        st_d.refd = st_q.sh[REF_W-1:0];
                    end
                endcase
            end
            if (st_q.sen_lvl && st_q.cnt == BITCNT_W'(CAP_W)) begin
                commit_hi = 1'b1;
                st_d.cap  = st_q.sh[CAP_W-1:0];
            end
        end else if (sclk_s_i && !st_q.sclk_prev) begin
            st_d.sh = {st_q.sh[FRAME_W-2:0], sdat_s_i};
            if (st_q.cnt != '1) st_d.cnt = st_q.cnt + BITCNT_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q      <= '0;
            st_q.ctrl <= CTRL_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_o        = st_q.tx;
    assign rx_o        = st_q.rx;
    assign ctrl_o      = st_q.ctrl;
    assign ref_o       = st_q.refd;
    assign opt_o       = st_q.opt;
    assign cap_o       = st_q.cap;
    assign commit_lo_o = commit_lo;
    assign commit_hi_o = commit_hi;
endmodule

// File: rtl/tw_clkdiv.sv
module tw_clkdiv
    import tw_prog_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             gate_i,
    output logic             clk_o,
    output logic             on_act_o,
    output logic [DIV_W-1:0] div_act_o
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [DIV_W-1:0] div;
        logic             on;
        logic             out;
    } div_t;

    div_t dv_d, dv_q;

    always_comb begin
        dv_d = dv_q;
        if (dv_q.cnt == dv_q.div - DIV_W'(1)) begin
            dv_d.cnt = '0;
            dv_d.div = DIV_W'(sel_i) + DIV_W'(2);
            dv_d.on  = gate_i;
        end else begin
            dv_d.cnt = dv_q.cnt + DIV_W'(1);
        end
        dv_d.out = dv_d.on && (dv_d.cnt < (dv_d.div >> 1));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            dv_q.cnt <= DIV_W'(1);
            dv_q.div <= DIV_W'(2);
            dv_q.on  <= 1'b1;
            dv_q.out <= 1'b0;
        end else begin
            dv_q <= dv_d;
        end
    end

    assign clk_o     = dv_q.out;
    assign on_act_o  = dv_q.on;
    assign div_act_o = dv_q.div;
endmodule

// File: rtl/tw_prog_if.sv
module tw_prog_if
    import tw_prog_pkg::*;
#(
    parameter int CAP_W       = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             ser_clk_i,
    input  logic             ser_dat_i,
    input  logic             ser_en_i,
    output logic [13:0]      tx_div_o,
    output logic [13:0]      rx_div_o,
    output logic [13:0]      ctrl_o,
    output logic [11:0]      ref_div_o,
    output logic [1:0]       ref_opt_o,
    output logic [CAP_W-1:0] lo_cap_o,
    output logic             host_clk_o
);
    logic [2:0]       line_s;
    logic             commit_lo, commit_hi;
    logic             on_act;
    logic [DIV_W-1:0] div_act;
    logic [CNT_W-1:0] ctrl_w;

    tw_sync #(.LINES(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i ({ser_en_i, ser_dat_i, ser_clk_i}),
        .sync_o  (line_s)
    );

    tw_frame_rx #(.CAP_W(CAP_W)) u_rx (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .sclk_s_i    (line_s[0]),
        .sdat_s_i    (line_s[1]),
        .sen_s_i     (line_s[2]),
        .tx_o        (tx_div_o),
        .rx_o        (rx_div_o),
        .ctrl_o      (ctrl_w),
        .ref_o       (ref_div_o),
        .opt_o       (ref_opt_o),
        .cap_o       (lo_cap_o),
        .commit_lo_o (commit_lo),
        .commit_hi_o (commit_hi)
    );

    assign ctrl_o = ctrl_w;

    tw_clkdiv u_div (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .sel_i     (ctrl_w[SEL_W-1:0]),
        .gate_i    (ctrl_w[GATE_BIT]),
        .clk_o     (host_clk_o),
        .on_act_o  (on_act),
        .div_act_o (div_act)
    );
endmodule

// File: rtl/tw_prog_if_chk.sv
module tw_prog_if_chk
    import tw_prog_pkg::*;
#(
    parameter int CAP_W = 6
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [13:0]      tx_div_o,
    input logic [13:0]      rx_div_o,
    input logic [13:0]      ctrl_o,
    input logic [11:0]      ref_div_o,
    input logic [1:0]       ref_opt_o,
    input logic [CAP_W-1:0] lo_cap_o,
    input logic             host_clk_o,
    input logic             commit_lo,
    input logic             commit_hi,
    input logic             on_act,
    input logic [DIV_W-1:0] div_act
);
    logic [55:0] lo_regs;
    assign lo_regs = {tx_div_o, rx_div_o, ctrl_o, ref_div_o, ref_opt_o};

    p_lo_commit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(lo_regs) |-> $past(commit_lo));

    p_cap_commit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(lo_cap_o) |-> $past(commit_hi));

    p_cap_isolated_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        commit_hi |=> $stable(lo_regs));

    p_ctrl_default_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) |-> (ctrl_o == CTRL_RST));

    p_high_run_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (host_clk_o && $past(host_clk_o)) |=> !host_clk_o);

    p_switch_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!$stable(on_act) || !$stable(div_act)) |-> $past(!host_clk_o));
endmodule

bind tw_prog_if tw_prog_if_chk #(.CAP_W(CAP_W)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tx_div_o   (tx_div_o),
    .rx_div_o   (rx_div_o),
    .ctrl_o     (ctrl_o),
    .ref_div_o  (ref_div_o),
    .ref_opt_o  (ref_opt_o),
    .lo_cap_o   (lo_cap_o),
    .host_clk_o (host_clk_o),
    .commit_lo  (commit_lo),
    .commit_hi  (commit_hi),
    .on_act     (on_act),
    .div_act    (div_act)
);

// File: tb/tb_tw_prog_if.sv
module tb_tw_prog_if;
    localparam int CLK_PERIOD = 10;
    localparam int CAP_W = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, sdat = 1'b0, sen = 1'b1;
    logic [13:0] tx_div, rx_div, ctrl;
    logic [11:0] ref_div;
    logic [1:0]  ref_opt;
    logic [CAP_W-1:0] lo_cap;
    logic host_clk;

    int n_chk = 0, n_fail = 0;
    logic [13:0] e_tx = '0, e_rx = '0, e_ctrl = 14'h0004;
    logic [11:0] e_ref = '0;
    logic [1:0]  e_opt = '0;
    logic [CAP_W-1:0] e_cap = '0;

    logic mon_on = 1'b0;
    logic mon_first = 1'b1, mon_valid = 1'b0, mon_prev = 1'b0;
    int   mon_run = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tw_prog_if #(.CAP_W(CAP_W)) dut (
        .clk_i(clk), .rst_ni(rst_n),
        .ser_clk_i(sclk), .ser_dat_i(sdat), .ser_en_i(sen),
        .tx_div_o(tx_div), .rx_div_o(rx_div), .ctrl_o(ctrl),
        .ref_div_o(ref_div), .ref_opt_o(ref_opt), .lo_cap_o(lo_cap),
        .host_clk_o(host_clk)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic check_regs(input string req);
        check(req, "tx_div", 32'(tx_div), 32'(e_tx));
        check(req, "rx_div", 32'(rx_div), 32'(e_rx));
        check(req, "ctrl", 32'(ctrl), 32'(e_ctrl));
        check(req, "ref_div", 32'(ref_div), 32'(e_ref));
        check(req, "ref_opt", 32'(ref_opt), 32'(e_opt));
        check(req, "lo_cap", 32'(lo_cap), 32'(e_cap));
    endtask

    task automatic shift_bits(input logic [31:0] w, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            sdat = w[i];
            repeat (4) @(negedge clk);
            sclk = 1'b1;
            repeat (4) @(negedge clk);
            sclk = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic lo_frame(input logic [31:0] w, input int n);
        sen = 1'b0;
        repeat (4) @(negedge clk);
        shift_bits(w, n);
        sen = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic hi_frame(input logic [31:0] w, input int n);
        repeat (4) @(negedge clk);
        shift_bits(w, n);
        sen = 1'b0;
        repeat (8) @(negedge clk);
        sen = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic measure(output int hi, output int lo);
        @(negedge clk);
        while (host_clk !== 1'b0) @(negedge clk);
        while (host_clk !== 1'b1) @(negedge clk);
        hi = 0;
        while (host_clk === 1'b1) begin hi++; @(negedge clk); end
        lo = 0;
        while (host_clk === 1'b0) begin lo++; @(negedge clk); end
    endtask

    task automatic write_ctrl(input logic [13:0] v);
        lo_frame({16'h0, 2'b10, v}, 16);
        e_ctrl = v;
    endtask

    // R9 monitor: run lengths of the host clock while it runs
    always @(negedge clk) begin
        if (mon_on) begin
            if (mon_first) begin
                mon_prev = host_clk; mon_run = 1; mon_first = 1'b0;
            end else if (host_clk == mon_prev) begin
                mon_run++;
            end else begin
                if (mon_valid) begin
                    n_chk++;
                    if (mon_run < 1 || mon_run > (mon_prev ? 2 : 3)) begin
                        n_fail++;
                        $display("FAIL R9 run of level %0b: actual %0d expected 1..%0d",
                                 mon_prev, mon_run, mon_prev ? 2 : 3);
                    end
                end
                mon_valid = 1'b1; mon_prev = host_clk; mon_run = 1;
            end
        end else begin
            mon_first = 1'b1; mon_valid = 1'b0;
        end
    end

    task automatic t_reset;
        int hi, lo;
        check_regs("R6");
        measure(hi, lo);
        check("R7", "default /2 high", 32'(hi), 32'd1);
        check("R7", "default /2 low", 32'(lo), 32'd1);
    endtask

    task automatic t_counters;
        lo_frame({16'h0, 2'b00, 14'h2A5C}, 16); e_tx = 14'h2A5C;
        check_regs("R1 R2 tx");
        lo_frame({16'h0, 2'b01, 14'h13C7}, 16); e_rx = 14'h13C7;
        check_regs("R2 rx");
    endtask

    task automatic t_reference;
        lo_frame({16'h0, 2'b11, 2'b10, 12'hABC}, 16);
        e_opt = 2'b10; e_ref = 12'hABC;
        check_regs("R3");
    endtask

    task automatic t_length;
        lo_frame({17'h0, 2'b00, 13'h0F0F}, 15);
        check_regs("R4 short frame");
        lo_frame({15'h0, 2'b01, 14'h3FFF, 1'b1}, 17);
        check_regs("R4 long frame");
    endtask

    task automatic t_cap;
        hi_frame(32'b101101, CAP_W);
        e_cap = 6'b101101;
        check_regs("R5 capacitor frame");
        hi_frame(32'b01010, CAP_W - 1);
        check_regs("R5 short capacitor frame");
        hi_frame(32'b1110001, CAP_W + 1);
        check_regs("R5 long capacitor frame");
    endtask

    task automatic t_ratio;
        int hi, lo;
        int exp_hi [4] = '{1, 1, 2, 2};
        int exp_lo [4] = '{1, 2, 2, 3};
        mon_on = 1'b1;
        for (int s = 1; s < 4; s++) begin
            write_ctrl(14'h3F00 | 14'h0004 | 14'(s));
            check("R7", "ctrl word", 32'(ctrl), 32'(e_ctrl));
            repeat (10) @(negedge clk);
            measure(hi, lo);
            check("R7", $sformatf("ratio %0d high", s), 32'(hi), 32'(exp_hi[s]));
            check("R7", $sformatf("ratio %0d low", s), 32'(lo), 32'(exp_lo[s]));
        end
        mon_on = 1'b0;
    endtask

    task automatic t_gate;
        int highs;
        int hi, lo;
        write_ctrl(14'h0002);
        repeat (10) @(negedge clk);
        highs = 0;
        for (int i = 0; i < 20; i++) begin
            if (host_clk !== 1'b0) highs++;
            @(negedge clk);
        end
        check("R8", "high samples while gated off", 32'(highs), 32'd0);
        write_ctrl(14'h0006);
        repeat (10) @(negedge clk);
        measure(hi, lo);
        check("R8", "regated /4 high", 32'(hi), 32'd2);
        check("R8", "regated /4 low", 32'(lo), 32'd2);
    endtask

    task automatic t_switch;
        int hi, lo;
        mon_on = 1'b1;
        write_ctrl(14'h0007);
        write_ctrl(14'h0004);
        write_ctrl(14'h0005);
        write_ctrl(14'h0006);
        write_ctrl(14'h0007);
        measure(hi, lo);
        check("R9", "period after switch high", 32'(hi), 32'd2);
        check("R9", "period after switch low", 32'(lo), 32'd3);
        mon_on = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        t_reset();
        t_counters();
        t_reference();
        t_length();
        t_cap();
        t_ratio();
        t_gate();
        t_switch();
        check_regs("R5 final registers");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule